// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Saturation Flag

This block is a 32-bit arithmetic unit for signal-processing style code. Results are clamped to the representable range instead of wrapping. The datapath is purely combinational. An opcode selects one of several operations:

- signed and unsigned add;
- signed and unsigned subtract;
- a signed doubling;
- a plain wrapping add that only reports signed overflow;
- clamping of a value to a chosen bit position, either on the whole word or on the two 16-bit halves independently.

Every operation that has to clamp raises a single shared flag. The flag is registered and sticky. Once set, it stays set until software pulses the clear input or the block is reset. A caller issues an operation by holding `op_en_i` high for one cycle. The result is available in the same cycle. The flag reflects the operation from the next rising edge onward.

Top module: `sat_unit`

## Requirements
- R1: Opcode 0 (signed add): on signed overflow the result is 0x7FFFFFFF when a is non-negative and 0x80000000 when a is negative, and the operation reports saturation; otherwise the result is a+b.
- R2: Opcode 1 (signed subtract): a-b, clamped in the same two directions as R1 on signed overflow, with saturation reported.
- R3: Opcode 2 (doubling of a): the result is 0x7FFFFFFF when a ≥ 0x40000000 (signed) and 0x80000000 when a ≤ 0xC0000000 (signed). Otherwise the result is a shifted left by one. Both clamp cases report saturation, including the input 0xC0000000 exactly.
- R4: Opcode 3 (unsigned add): when the 33-bit sum exceeds 0xFFFFFFFF, the result is 0xFFFFFFFF and saturation is reported.
- R5: Opcode 4 (unsigned subtract): when b > a (unsigned), the result is 0 and saturation is reported; otherwise the result is a-b.
- R6: Opcode 5 (signed clamp): a is limited to the range [-(2^s), 2^s-1], where s = pos_i (0..31). Saturation is reported when a lies outside that range.
- R7: Opcode 6 (unsigned clamp): negative a gives 0, and a above 2^s-1 gives 2^s-1. Saturation is reported in both cases.
- R8: Opcode 7 (dual-halfword signed clamp): bits 15:0 and bits 31:16 of a are each taken as signed 16-bit values. Each is clamped as in R6 with s = pos_i[3:0]. The low half of the result is placed in bits 15:0 and the high half in bits 31:16. pos_i[4] has no effect.
- R9: Opcode 8 (dual-halfword unsigned clamp): the same layout as R8, with each half clamped as in R7 using s = pos_i[3:0].
- R10: Opcode 9 (flag-only add): the result is the wrapped sum a+b. Saturation is reported exactly on signed overflow.
- R11: When `op_en_i` is high and the selected operation reports saturation, `flag_o` is 1 after the next rising edge. Once set, `flag_o` stays 1 across later non-saturating operations.
- R12: `clr_i` high at a rising edge makes `flag_o` 0 after that edge, even if a saturating operation is enabled in the same cycle. `flag_o` is 0 after reset.
- R13: With `op_en_i` low, `flag_o` does not change, while `res_o` still shows the selected operation's result.
- R14: Opcodes 10 to 15 give a result of 0 and never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_en_i | input | 1 | Issue strobe; lets the operation update the flag |
| clr_i | input | 1 | Synchronous clear of the sticky flag |
| op_i | input | 4 | Operation select |
| a_i | input | 32 | First operand / value to clamp |
| b_i | input | 32 | Second operand |
| pos_i | input | 5 | Clamp bit position |
| res_o | output | 32 | Combinational result |
| flag_o | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that the operands, opcode, position and both strobes are known, settled values at each rising edge once reset has been released. The result checks assume the inputs do not change between an edge and the combinational settling of `res_o`. The bench meets these assumptions by driving every input from the falling edge only, at known values from time zero. It sweeps all sixteen opcodes over a fixed set of corner operands, and covers every one of the 32 positions for the clamp modes. It clears the flag between vectors, so each flag observation belongs to exactly one operation.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [3:0] {
    OP_SADD     = 4'd0,
    OP_SSUB     = 4'd1,
    OP_SDBL     = 4'd2,
    OP_UADD     = 4'd3,
    OP_USUB     = 4'd4,
    OP_SCLAMP   = 4'd5,
    OP_UCLAMP   = 4'd6,
    OP_SCLAMP_H = 4'd7,
    OP_UCLAMP_H = 4'd8,
    OP_ADD_OVF  = 4'd9
  } sat_op_e;
endpackage

// File: rtl/sat_arith.sv
module sat_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  sat_pkg::sat_op_e op_i,
  output logic [W-1:0]     res_o,
  output logic             sat_o
);
  import sat_pkg::*;

  localparam logic [W-1:0]        MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]        MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] QPOS = W'(1) << (W - 2);
  localparam logic signed [W-1:0] QNEG = -QPOS;

  logic [W-1:0]        sum, dif, lim;
  logic signed [W-1:0] a_s;
  logic                s_add_ov, s_sub_ov, u_add_ov, u_sub_ov, dbl_hi, dbl_lo;

  always_comb begin
    a_s      = a_i;
    sum      = a_i + b_i;
    dif      = a_i - b_i;
    lim      = a_i[W-1] ? MINV : MAXV;
    s_add_ov = (sum[W-1] ^ a_i[W-1]) & ~(a_i[W-1] ^ b_i[W-1]);
    s_sub_ov = (dif[W-1] ^ a_i[W-1]) &  (a_i[W-1] ^ b_i[W-1]);
    u_add_ov = sum < a_i;
    u_sub_ov = dif > a_i;
    dbl_hi   = a_s >= QPOS;
    dbl_lo   = a_s <= QNEG;

    res_o = '0;
    sat_o = 1'b0;
    case (op_i)
      OP_SADD: begin
        res_o = s_add_ov ? lim : sum;
        sat_o = s_add_ov;
      end
      OP_SSUB: begin
        res_o = s_sub_ov ? lim : dif;
        sat_o = s_sub_ov;
      end
      OP_SDBL: begin
        if (dbl_hi) begin
          res_o = MAXV;
          sat_o = 1'b1;
        end else if (dbl_lo) begin
          res_o = MINV;
          sat_o = 1'b1;
        end else begin
          res_o = {a_i[W-2:0], 1'b0};
        end
      end
      OP_UADD: begin
        res_o = u_add_ov ? '1 : sum;
        sat_o = u_add_ov;
      end
      OP_USUB: begin
        res_o = u_sub_ov ? '0 : dif;
        sat_o = u_sub_ov;
      end
      OP_ADD_OVF: begin
        res_o = sum;
        sat_o = s_add_ov;
      end
      default: begin
        res_o = '0;
        sat_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int N  = 32,
  parameter int SW = $clog2(N)
) (
  input  logic [N-1:0]  val_i,
  input  logic [SW-1:0] sh_i,
  input  logic          sgn_i,
  output logic [N-1:0]  res_o,
  output logic          sat_o
);
  logic signed [N-1:0] top;
  logic [N-1:0]        mask;
  logic                above, below;

  always_comb begin
    top   = $signed(val_i) >>> sh_i;
    mask  = (N'(1) << sh_i) - N'(1);
    above = !val_i[N-1] && (top != '0);
    below = val_i[N-1] && (sgn_i ? (top != '1) : 1'b1);
    res_o = val_i;
    sat_o = 1'b0;
    if (above) begin
      res_o = mask;
      sat_o = 1'b1;
    end else if (below) begin
      res_o = sgn_i ? ~mask : '0;
      sat_o = 1'b1;
    end
  end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d, flag_q;

  always_comb begin
    flag_d = flag_q;
    if (clr_i)      flag_d = 1'b0;
    else if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sat_unit.sv
module sat_unit #(
  parameter int W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 op_en_i,
  input  logic                 clr_i,
  input  logic [3:0]           op_i,
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  input  logic [$clog2(W)-1:0] pos_i,
  output logic [W-1:0]         res_o,
  output logic                 flag_o
);
  import sat_pkg::*;

  localparam int PW  = $clog2(W);
  localparam int H   = W / 2;
  localparam int HPW = PW - 1;

  sat_op_e      op_e;
  logic [W-1:0] ar_res, cl_res;
  logic         ar_sat, cl_sat;
  logic [H-1:0] half_res [2];
  logic [1:0]   half_sat;
  logic [W-1:0] res_c;
  logic         sat_c;

  assign op_e = sat_op_e'(op_i);

  sat_arith #(.W(W)) u_arith (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (op_e),
    .res_o (ar_res),
    .sat_o (ar_sat)
  );

  sat_clamp #(.N(W), .SW(PW)) u_clamp_word (
    .val_i (a_i),
    .sh_i  (pos_i),
    .sgn_i (op_e == OP_SCLAMP),
    .res_o (cl_res),
    .sat_o (cl_sat)
  );

  for (genvar g = 0; g < 2; g++) begin : g_half
    sat_clamp #(.N(H), .SW(HPW)) u_clamp_half (
      .val_i (a_i[g*H +: H]),
      .sh_i  (pos_i[HPW-1:0]),
      .sgn_i (op_e == OP_SCLAMP_H),
      .res_o (half_res[g]),
      .sat_o (half_sat[g])
    );
  end

  always_comb begin
    res_c = '0;
    sat_c = 1'b0;
    case (op_e)
      OP_SADD, OP_SSUB, OP_SDBL, OP_UADD, OP_USUB, OP_ADD_OVF: begin
        res_c = ar_res;
        sat_c = ar_sat;
      end
      OP_SCLAMP, OP_UCLAMP: begin
        res_c = cl_res;
        sat_c = cl_sat;
      end
      OP_SCLAMP_H, OP_UCLAMP_H: begin
        res_c = {half_res[1], half_res[0]};
        sat_c = |half_sat;
      end
      default: begin
        res_c = '0;
        sat_c = 1'b0;
      end
    endcase
  end

  assign res_o = res_c;

  sat_sticky u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (op_en_i & sat_c),
    .clr_i  (clr_i),
    .flag_o (flag_o)
  );
endmodule

// File: rtl/sat_unit_chk.sv
module sat_unit_chk #(
  parameter int W = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 op_en_i,
  input logic                 clr_i,
  input logic [3:0]           op_i,
  input logic [W-1:0]         a_i,
  input logic [W-1:0]         b_i,
  input logic [$clog2(W)-1:0] pos_i,
  input logic [W-1:0]         res_o,
  input logic                 flag_o
);
  AST_SADD_KEEPS_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd0 && a_i[W-1] == b_i[W-1]) |-> res_o[W-1] == a_i[W-1]); // R1
  AST_UADD_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd3) |-> res_o >= a_i); // R4
  AST_USUB_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd4) |-> res_o <= a_i); // R5
  AST_UCLAMP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd6) |-> (res_o >> pos_i) == '0); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o); // R11
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_o); // R12
  AST_IDLE_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_en_i && !clr_i && !flag_o) |=> !flag_o); // R13
  AST_UNKNOWN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 4'd10) |-> res_o == '0); // R14
endmodule

bind sat_unit sat_unit_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .op_en_i (op_en_i),
  .clr_i   (clr_i),
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .pos_i   (pos_i),
  .res_o   (res_o),
  .flag_o  (flag_o)
);

// File: tb/tb_sat_unit.sv
module tb_sat_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        op_en_i;
  logic        clr_i;
  logic [3:0]  op_i;
  logic [31:0] a_i, b_i;
  logic [4:0]  pos_i;
  logic [31:0] res_o;
  logic        flag_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sat_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_en_i(op_en_i), .clr_i(clr_i),
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .pos_i(pos_i),
    .res_o(res_o), .flag_o(flag_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] corner(int i);
    case (i)
      0:  return 32'h0000_0000;  1:  return 32'h0000_0001;
      2:  return 32'h7FFF_FFFF;  3:  return 32'h8000_0000;
      4:  return 32'hFFFF_FFFF;  5:  return 32'h0000_8000;
      6:  return 32'h7FFF_0001;  7:  return 32'h1234_5678;
      8:  return 32'hFFFF_8000;  9:  return 32'h0001_FFFF;
      10: return 32'hC000_0000;  11: return 32'h4000_0000;
      12: return 32'h3FFF_FFFF;  13: return 32'h0000_0100;
      14: return 32'h8000_7FFF;  default: return 32'hFFFF_FF00;
    endcase
  endfunction

  function automatic string req_of(int op);
    case (op)
      0: return "R1";  1: return "R2";  2: return "R3";  3: return "R4";
      4: return "R5";  5: return "R6";  6: return "R7";  7: return "R8";
      8: return "R9";  9: return "R10"; default: return "R14";
    endcase
  endfunction

  task automatic clamp(input longint v, input int s, input bit sgn,
                       output longint r, output bit f);
    longint one, hi, lo;
    one = 1;
    hi  = (one << s) - 1;
    lo  = sgn ? -(one << s) : 0;
    f = 1'b1;
    if (v > hi)      r = hi;
    else if (v < lo) r = lo;
    else begin r = v; f = 1'b0; end
  endtask

  task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] p, output logic [31:0] r, output bit f);
    longint sa, sb, ua, ub, t, rl, rh;
    bit fl, fh;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'(a);          ub = longint'(b);
    r = '0; f = 1'b0;
    case (op)
      0, 1, 9: begin
        t = (op == 1) ? sa - sb : sa + sb;
        f = (t > 64'sd2147483647) || (t < -64'sd2147483648);
        if (op == 9)    r = a + b;
        else if (!f)    r = t[31:0];
        else            r = (sa < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      end
      2: begin
        if (sa >= 64'sd1073741824)       begin r = 32'h7FFF_FFFF; f = 1'b1; end
        else if (sa <= -64'sd1073741824) begin r = 32'h8000_0000; f = 1'b1; end
        else begin t = sa * 2; r = t[31:0]; end
      end
      3: begin
        t = ua + ub;
        if (t > 64'sd4294967295) begin r = '1; f = 1'b1; end
        else r = t[31:0];
      end
      4: begin
        if (ub > ua) begin r = '0; f = 1'b1; end
        else begin t = ua - ub; r = t[31:0]; end
      end
      5, 6: begin
        clamp(sa, int'(p), op == 5, t, f);
        r = t[31:0];
      end
      7, 8: begin
        clamp(longint'($signed(a[15:0])),  int'(p[3:0]), op == 7, rl, fl);
        clamp(longint'($signed(a[31:16])), int'(p[3:0]), op == 7, rh, fh);
        r = {rh[15:0], rl[15:0]};
        f = fl | fh;
      end
      default: begin r = '0; f = 1'b0; end
    endcase
  endtask

  task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s res actual=%h expected=%h (op=%0d a=%h b=%h pos=%0d)",
               req, act, exp, op_i, a_i, b_i, pos_i);
    end
  endtask

  task automatic check1(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s flag actual=%b expected=%b (op=%0d a=%h b=%h pos=%0d)",
               req, act, exp, op_i, a_i, b_i, pos_i);
    end
  endtask

  task automatic run_vec(input int op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] p);
    logic [31:0] er;
    bit ef;
    model(op, a, b, p, er, ef);
    @(negedge clk_i);
    op_i = 4'(op); a_i = a; b_i = b; pos_i = p; op_en_i = 1'b1; clr_i = 1'b0;
    #1;
    check32(res_o, er, req_of(op));
    @(negedge clk_i);
    op_en_i = 1'b0;
    check1(flag_o, ef, (op >= 10) ? "R14" : "R11");
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_ni = 1'b0; op_en_i = 1'b0; clr_i = 1'b0;
    op_i = '0; a_i = '0; b_i = '0; pos_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check1(flag_o, 1'b0, "R12 reset");

    for (int op = 0; op < 16; op++) begin
      if (op >= 5 && op <= 8) begin
        for (int p = 0; p < 32; p++)
          for (int i = 0; i < 16; i++)
            run_vec(op, corner(i), 32'h0, 5'(p));
      end else begin
        for (int i = 0; i < 16; i++)
          for (int j = 0; j < 16; j++)
            run_vec(op, corner(i), corner(j), 5'd0);
      end
    end

    // R11: flag stays set across a later non-saturating operation
    @(negedge clk_i);
    op_i = 4'd0; a_i = 32'h7FFF_FFFF; b_i = 32'h1; op_en_i = 1'b1;
    @(negedge clk_i);
    check1(flag_o, 1'b1, "R11 set");
    a_i = 32'h1; b_i = 32'h1;
    @(negedge clk_i);
    @(negedge clk_i);
    op_en_i = 1'b0;
    check1(flag_o, 1'b1, "R11 hold");

    // R12: clear wins over a simultaneous saturating operation
    op_i = 4'd3; a_i = '1; b_i = 32'h5; op_en_i = 1'b1; clr_i = 1'b1;
    @(negedge clk_i);
    check1(flag_o, 1'b0, "R12 clear priority");
    clr_i = 1'b0; op_en_i = 1'b0;

    // R13: saturating operation without issue leaves the flag alone
    op_i = 4'd2; a_i = 32'h4000_0000;
    #1;
    check32(res_o, 32'h7FFF_FFFF, "R13 result");
    @(negedge clk_i);
    @(negedge clk_i);
    check1(flag_o, 1'b0, "R13 no set");

    // R14: unknown opcode never sets the flag even with operands that would
    op_i = 4'd12; a_i = 32'h7FFF_FFFF; b_i = 32'h7FFF_FFFF; op_en_i = 1'b1;
    #1;
    check32(res_o, 32'h0, "R14 result");
    @(negedge clk_i);
    op_en_i = 1'b0;
    check1(flag_o, 1'b0, "R14 flag");

    summary();
  end
endmodule